// File: doc/BRIEF.md
# Logical Compare Flag Execution Unit

This block executes the AND-and-discard compare of a 64-bit integer core. Each strobed input carries the primary opcode byte, the ModRM byte, the prefix indicators and an immediate. The block reports which registers it needs on two combinational read-port indexes and takes the returned values back in the same cycle. A memory-form operand arrives on its own input, already fetched. From these the block works out the operand width and the two sources, forms their bitwise AND at that width, and produces the new status flags together with a write mask. The AND result itself never leaves the block.

One cycle after each strobe the block presents a registered result with a valid bit. The result says whether the input was recognised as this instruction, whether it must raise an invalid-opcode exception, the five flag values, and which of those flags the core should write. The auxiliary-carry flag is not produced and is never in the mask, so the core leaves it alone.

Top module: `lcmp_flag_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. All other outputs change only on a strobe.
- R2: Opcodes 0xA8, 0xF6 and 0x84 operate on 8 bits, and so do their prefixed versions. Opcodes 0xA9, 0xF7 and 0x85 operate on 64 bits when `rex_w` is set, on 16 bits when `opsize_ovr` is set and `rex_w` is clear, and on 32 bits otherwise.
- R3: The sign flag (`out_flags[3]`) equals the most significant bit of the AND at the active width.
- R4: The zero flag (`out_flags[2]`) is 1 exactly when the AND is zero at the active width. Operand bits above that width have no effect.
- R5: The parity flag (`out_flags[1]`) is 1 when bits 7:0 of the AND hold an even number of ones, at every width.
- R6: On a recognised form without LOCK, the carry flag (`out_flags[0]`) and the overflow flag (`out_flags[4]`) are 0 and `out_wmask` is 5'b11111. Auxiliary carry is not part of either vector.
- R7: Source selection depends on the opcode. 0xA8/0xA9 AND register 0 with the immediate. 0xF6/0xF7 AND the r/m operand with the immediate. 0x84/0x85 AND the r/m operand with the ModRM reg operand. When ModRM bits 7:6 are not 2'b11, the r/m operand is `mem_data`.
- R8: At 64 bits, the 32-bit immediate is sign-extended from bit 31 before the AND.
- R9: Any other opcode, and 0xF6/0xF7 with ModRM bits 5:3 not 0, gives `out_match`=0, `out_ud`=0 and `out_wmask`=0.
- R10: A recognised form with `lock_pfx` set gives `out_match`=1, `out_ud`=1 and `out_wmask`=0.
- R11: For 8-bit register operands without REX, encodings 0–3 read bits 7:0 of registers 0–3 and encodings 4–7 read bits 15:8 of registers 0–3. With any REX, the index is {extension bit, encoding} and bits 7:0 are read.
- R12: `rex_r` extends the ModRM reg field and `rex_b` extends the r/m field to a 4-bit index. Both are ignored when `rex_present` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| opcode | input | 8 | Primary opcode byte |
| modrm | input | 8 | ModRM byte |
| rex_present | input | 1 | A REX prefix is present |
| rex_w | input | 1 | REX.W bit |
| rex_r | input | 1 | REX.R bit |
| rex_b | input | 1 | REX.B bit |
| opsize_ovr | input | 1 | Operand-size override prefix present |
| lock_pfx | input | 1 | LOCK prefix present |
| imm | input | 32 | Immediate, right-aligned |
| mem_data | input | 64 | Fetched memory operand |
| rd_rm_idx | output | 4 | Register index for the r/m or accumulator operand |
| rd_rm_data | input | 64 | Register value at `rd_rm_idx` |
| rd_reg_idx | output | 4 | Register index for the ModRM reg operand |
| rd_reg_data | input | 64 | Register value at `rd_reg_idx` |
| out_valid | output | 1 | Result valid |
| out_match | output | 1 | Input was this instruction |
| out_ud | output | 1 | Invalid-opcode exception |
| out_flags | output | 5 | {OF, SF, ZF, PF, CF} |
| out_wmask | output | 5 | Flag write enables, same order |

## Verification
Two pairs of functions can act in the same cycle. In the first, the exception check and the flag computation both act on one input. A locked 0x85 is sent in the middle of a back-to-back stream, and it passes only if `out_ud` rises while the write mask drops to zero. The transactions on either side must keep their full masks. In the second, the zero, sign and parity results all come from one AND result. Cases are chosen so that the upper operand bits are nonzero while the result at the active width is zero. The scoreboard then checks that ZF is set, SF is clear and PF reads even in that same result.

// File: rtl/lcmp_pkg.sv
package lcmp_pkg;

  localparam int unsigned XLEN   = 64;
  localparam int unsigned IMM_W  = 32;
  localparam int unsigned RIDX_W = 4;
  localparam int unsigned NFLAGS = 5;

  localparam int unsigned FLG_CF = 0;
  localparam int unsigned FLG_PF = 1;
  localparam int unsigned FLG_ZF = 2;
  localparam int unsigned FLG_SF = 3;
  localparam int unsigned FLG_OF = 4;

  localparam logic [7:0] OPC_ACC8  = 8'hA8;
  localparam logic [7:0] OPC_ACCF  = 8'hA9;
  localparam logic [7:0] OPC_GRP8  = 8'hF6;
  localparam logic [7:0] OPC_GRPF  = 8'hF7;
  localparam logic [7:0] OPC_RR8   = 8'h84;
  localparam logic [7:0] OPC_RRF   = 8'h85;

  typedef enum logic [1:0] {W8, W16, W32, W64} width_e;
  typedef enum logic [1:0] {SRC_ACC_IMM, SRC_RM_IMM, SRC_RM_REG} src_e;

  function automatic logic [XLEN-1:0] width_mask(width_e w);
    case (w)
      W8:      return XLEN'(8'hFF);
      W16:     return XLEN'(16'hFFFF);
      W32:     return XLEN'(32'hFFFF_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic msb_at(logic [XLEN-1:0] v, width_e w);
    case (w)
      W8:      return v[7];
      W16:     return v[15];
      W32:     return v[31];
      default: return v[XLEN-1];
    endcase
  endfunction

  function automatic logic even_ones8(logic [7:0] b);
    return ~^b;
  endfunction

  function automatic logic [XLEN-1:0] extend_imm(logic [IMM_W-1:0] i, width_e w);
    if (w == W64) return {{(XLEN-IMM_W){i[IMM_W-1]}}, i};
    return {{(XLEN-IMM_W){1'b0}}, i} & width_mask(w);
  endfunction

  function automatic logic [XLEN-1:0] pick_byte(logic [XLEN-1:0] v, logic hi);
    return hi ? XLEN'(v[15:8]) : XLEN'(v[7:0]);
  endfunction

endpackage

// File: rtl/lcmp_decode.sv
module lcmp_decode
  import lcmp_pkg::*;
(
  input  logic [7:0]        opcode,
  input  logic [7:0]        modrm,
  input  logic              rex_present,
  input  logic              rex_w,
  input  logic              rex_r,
  input  logic              rex_b,
  input  logic              opsize_ovr,
  input  logic              lock_pfx,
  output logic              match,
  output logic              ud,
  output width_e            width,
  output src_e              src,
  output logic              rm_mem,
  output logic              rm_hi,
  output logic              reg_hi,
  output logic [RIDX_W-1:0] rm_idx,
  output logic [RIDX_W-1:0] reg_idx
);

  logic is_byte, is_full, is_grp, grp_ok;
  logic [2:0] rm_enc, reg_enc;

  assign rm_enc  = modrm[2:0];
  assign reg_enc = modrm[5:3];

  assign is_byte = (opcode == OPC_ACC8) || (opcode == OPC_GRP8) || (opcode == OPC_RR8);
  assign is_full = (opcode == OPC_ACCF) || (opcode == OPC_GRPF) || (opcode == OPC_RRF);
  assign is_grp  = (opcode == OPC_GRP8) || (opcode == OPC_GRPF);
  assign grp_ok  = !is_grp || (reg_enc == 3'd0);

  assign match = (is_byte || is_full) && grp_ok;
  assign ud    = match && lock_pfx;

  always_comb begin
    if (is_byte)         width = W8;
    else if (rex_w)      width = W64;
    else if (opsize_ovr) width = W16;
    else                 width = W32;
  end

  always_comb begin
    if ((opcode == OPC_ACC8) || (opcode == OPC_ACCF))     src = SRC_ACC_IMM;
    else if (is_grp)                                      src = SRC_RM_IMM;
    else                                                  src = SRC_RM_REG;
  end

  assign rm_mem = (src != SRC_ACC_IMM) && (modrm[7:6] != 2'b11);

  function automatic logic [RIDX_W-1:0] map_idx(logic [2:0] enc, logic ext,
                                                logic rexp, logic hi);
    if (rexp) return {ext, enc};
    if (hi)   return {2'b00, enc[1:0]};
    return {1'b0, enc};
  endfunction

  logic rm_hi_raw;
  assign rm_hi_raw = is_byte && !rex_present && rm_enc[2];
  assign reg_hi    = is_byte && !rex_present && reg_enc[2];
  assign rm_hi     = (src == SRC_ACC_IMM) ? 1'b0 : rm_hi_raw;

  assign rm_idx  = (src == SRC_ACC_IMM) ? '0
                                        : map_idx(rm_enc, rex_b, rex_present, rm_hi_raw);
  assign reg_idx = map_idx(reg_enc, rex_r, rex_present, reg_hi);

endmodule

// File: rtl/lcmp_opsel.sv
module lcmp_opsel
  import lcmp_pkg::*;
(
  input  width_e            width,
  input  src_e              src,
  input  logic              rm_mem,
  input  logic              rm_hi,
  input  logic              reg_hi,
  input  logic [XLEN-1:0]   rd_rm_data,
  input  logic [XLEN-1:0]   rd_reg_data,
  input  logic [XLEN-1:0]   mem_data,
  input  logic [IMM_W-1:0]  imm,
  output logic [XLEN-1:0]   src1,
  output logic [XLEN-1:0]   src2
);

  logic [XLEN-1:0] wmask, rm_raw, reg_raw, imm_ext;
  logic            byte_op;

  assign wmask   = width_mask(width);
  assign byte_op = (width == W8);

  always_comb begin
    if (rm_mem)       rm_raw = mem_data;
    else if (byte_op) rm_raw = pick_byte(rd_rm_data, rm_hi);
    else              rm_raw = rd_rm_data;
  end

  assign reg_raw = byte_op ? pick_byte(rd_reg_data, reg_hi) : rd_reg_data;
  assign imm_ext = extend_imm(imm, width);

  assign src1 = rm_raw & wmask;
  assign src2 = ((src == SRC_RM_REG) ? reg_raw : imm_ext) & wmask;

endmodule

// File: rtl/lcmp_flagcalc.sv
module lcmp_flagcalc
  import lcmp_pkg::*;
(
  input  logic [XLEN-1:0]   src1,
  input  logic [XLEN-1:0]   src2,
  input  width_e            width,
  output logic [XLEN-1:0]   and_res,
  output logic [NFLAGS-1:0] flags
);

  always_comb begin
    and_res = (src1 & src2) & width_mask(width);
    flags         = '0;
    flags[FLG_SF] = msb_at(and_res, width);
    flags[FLG_ZF] = (and_res == '0);
    flags[FLG_PF] = even_ones8(and_res[7:0]);
    flags[FLG_CF] = 1'b0;
    flags[FLG_OF] = 1'b0;
  end

endmodule

// File: rtl/lcmp_flag_unit.sv
module lcmp_flag_unit
  import lcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [7:0]        modrm,
  input  logic              rex_present,
  input  logic              rex_w,
  input  logic              rex_r,
  input  logic              rex_b,
  input  logic              opsize_ovr,
  input  logic              lock_pfx,
  input  logic [31:0]       imm,
  input  logic [63:0]       mem_data,
  output logic [3:0]        rd_rm_idx,
  input  logic [63:0]       rd_rm_data,
  output logic [3:0]        rd_reg_idx,
  input  logic [63:0]       rd_reg_data,
  output logic              out_valid,
  output logic              out_match,
  output logic              out_ud,
  output logic [4:0]        out_flags,
  output logic [4:0]        out_wmask
);

  logic            dec_match_w, dec_ud_w, rm_mem_w, rm_hi_w, reg_hi_w;
  width_e          width_w;
  src_e            src_w;
  logic [XLEN-1:0] src1_w, src2_w, and_res_w;
  logic [NFLAGS-1:0] flags_w;

  // named internal events for the checker
  logic flag_wr_w, lock_kill_w;

  lcmp_decode u_decode (
    .opcode      (opcode),
    .modrm       (modrm),
    .rex_present (rex_present),
    .rex_w       (rex_w),
    .rex_r       (rex_r),
    .rex_b       (rex_b),
    .opsize_ovr  (opsize_ovr),
    .lock_pfx    (lock_pfx),
    .match       (dec_match_w),
    .ud          (dec_ud_w),
    .width       (width_w),
    .src         (src_w),
    .rm_mem      (rm_mem_w),
    .rm_hi       (rm_hi_w),
    .reg_hi      (reg_hi_w),
    .rm_idx      (rd_rm_idx),
    .reg_idx     (rd_reg_idx)
  );

  lcmp_opsel u_opsel (
    .width       (width_w),
    .src         (src_w),
    .rm_mem      (rm_mem_w),
    .rm_hi       (rm_hi_w),
    .reg_hi      (reg_hi_w),
    .rd_rm_data  (rd_rm_data),
    .rd_reg_data (rd_reg_data),
    .mem_data    (mem_data),
    .imm         (imm),
    .src1        (src1_w),
    .src2        (src2_w)
  );

  lcmp_flagcalc u_flagcalc (
    .src1    (src1_w),
    .src2    (src2_w),
    .width   (width_w),
    .and_res (and_res_w),
    .flags   (flags_w)
  );

  assign lock_kill_w = dec_ud_w;
  assign flag_wr_w   = dec_match_w && !dec_ud_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_match <= 1'b0;
      out_ud    <= 1'b0;
      out_flags <= '0;
      out_wmask <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_match <= dec_match_w;
        out_ud    <= lock_kill_w;
        out_flags <= flags_w;
        out_wmask <= {NFLAGS{flag_wr_w}};
      end
    end
  end

endmodule

// File: rtl/lcmp_flag_unit_chk.sv
module lcmp_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       rex_present,
  input logic [3:0] rd_rm_idx,
  input logic [3:0] rd_reg_idx,
  input logic       flag_wr_w,
  input logic       lock_kill_w,
  input logic       out_valid,
  input logic       out_match,
  input logic       out_ud,
  input logic [4:0] out_flags,
  input logic [4:0] out_wmask
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_flags) && $stable(out_wmask)));

  assert_cf_of_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wmask != 5'd0) |-> (!out_flags[0] && !out_flags[4]));

  assert_zero_coherent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_match && out_flags[2]) |-> (!out_flags[3] && out_flags[1]));

  assert_nomatch_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_match) |-> (!out_ud && out_wmask == 5'd0));

  assert_lock_suppress_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ud) |-> (out_match && out_wmask == 5'd0));

  assert_write_or_kill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_wr_w, lock_kill_w}));

  assert_no_ext_without_rex_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rex_present |-> (!rd_rm_idx[3] && !rd_reg_idx[3]));

endmodule

bind lcmp_flag_unit lcmp_flag_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .rex_present (rex_present),
  .rd_rm_idx   (rd_rm_idx),
  .rd_reg_idx  (rd_reg_idx),
  .flag_wr_w   (flag_wr_w),
  .lock_kill_w (lock_kill_w),
  .out_valid   (out_valid),
  .out_match   (out_match),
  .out_ud      (out_ud),
  .out_flags   (out_flags),
  .out_wmask   (out_wmask)
);

// File: tb/test_lcmp_flag_unit.sv
`timescale 1ns/1ps
module test_lcmp_flag_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = '0, modrm = '0;
  logic        rex_present = 1'b0, rex_w = 1'b0, rex_r = 1'b0, rex_b = 1'b0;
  logic        opsize_ovr = 1'b0, lock_pfx = 1'b0;
  logic [31:0] imm = '0;
  logic [63:0] mem_data = '0;
  logic [3:0]  rd_rm_idx, rd_reg_idx;
  logic [63:0] rd_rm_data, rd_reg_data;
  logic        out_valid, out_match, out_ud;
  logic [4:0]  out_flags, out_wmask;

  logic [63:0] rf [16];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  assign rd_rm_data  = rf[rd_rm_idx];
  assign rd_reg_data = rf[rd_reg_idx];

  lcmp_flag_unit i_lcmp_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .modrm(modrm),
    .rex_present(rex_present), .rex_w(rex_w), .rex_r(rex_r), .rex_b(rex_b),
    .opsize_ovr(opsize_ovr), .lock_pfx(lock_pfx), .imm(imm), .mem_data(mem_data),
    .rd_rm_idx(rd_rm_idx), .rd_rm_data(rd_rm_data), .rd_reg_idx(rd_reg_idx),
    .rd_reg_data(rd_reg_data), .out_valid(out_valid), .out_match(out_match),
    .out_ud(out_ud), .out_flags(out_flags), .out_wmask(out_wmask)
  );

  typedef struct {
    logic       match;
    logic       ud;
    logic [4:0] flags;
    logic [4:0] mask;
    string      tag;
  } item_t;

  item_t sb[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench-side register read following R11/R12
  function automatic logic [63:0] fetch(logic [2:0] enc, logic ext, logic rexp, logic bytew);
    logic [3:0] n;
    if (!bytew) begin
      n = rexp ? {ext, enc} : {1'b0, enc};
      return rf[n];
    end
    if (rexp) return rf[{ext, enc}] & 64'hFF;
    if (enc < 3'd4) return rf[{1'b0, enc}] & 64'hFF;
    return (rf[{2'b00, enc[1:0]}] >> 8) & 64'hFF;
  endfunction

  function automatic item_t model(logic [7:0] opc, logic [7:0] mrm, logic rexp, logic w,
                                  logic r, logic b, logic ovr, logic lk,
                                  logic [31:0] im, logic [63:0] mem, string tag);
    item_t it;
    bit bytew, fullw, grp;
    int nb;
    logic [63:0] a, c, m, t;
    bytew = (opc == 8'hA8) || (opc == 8'hF6) || (opc == 8'h84);
    fullw = (opc == 8'hA9) || (opc == 8'hF7) || (opc == 8'h85);
    grp   = (opc == 8'hF6) || (opc == 8'hF7);
    it.tag   = tag;
    it.match = (bytew || fullw) && !(grp && mrm[5:3] != 3'd0);
    it.ud    = it.match && lk;
    it.mask  = (it.match && !lk) ? 5'b11111 : 5'b00000;
    nb = bytew ? 8 : (w ? 64 : (ovr ? 16 : 32));
    m  = (nb == 64) ? '1 : ((64'd1 << nb) - 64'd1);
    if (opc == 8'hA8 || opc == 8'hA9) a = rf[0];
    else if (mrm[7:6] != 2'b11)       a = mem;
    else                              a = fetch(mrm[2:0], b, rexp, bytew);
    if (opc == 8'h84 || opc == 8'h85) c = fetch(mrm[5:3], r, rexp, bytew);
    else if (nb == 64)                c = {{32{im[31]}}, im};
    else                              c = {32'd0, im};
    t = a & c & m;
    it.flags    = 5'b00000;
    it.flags[3] = t[nb-1];
    it.flags[2] = (t == 64'd0);
    it.flags[1] = ~^t[7:0];
    return it;
  endfunction

  task automatic drive(input logic [7:0] opc, input logic [7:0] mrm, input logic rexp,
                       input logic w, input logic r, input logic b, input logic ovr,
                       input logic lk, input logic [31:0] im, input logic [63:0] mem,
                       input string tag);
    @(negedge clk);
    opcode = opc; modrm = mrm; rex_present = rexp; rex_w = w; rex_r = r; rex_b = b;
    opsize_ovr = ovr; lock_pfx = lk; imm = im; mem_data = mem; in_valid = 1'b1;
    sb.push_back(model(opc, mrm, rexp, w, r, b, ovr, lk, im, mem, tag));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops and compares at the falling edge after each registered result
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1 unexpected out_valid", 64'd1, 64'd0);
      end else begin
        item_t e;
        e = sb.pop_front();
        check(out_match == e.match, {e.tag, " match (R9)"}, 64'(out_match), 64'(e.match));
        check(out_ud == e.ud, {e.tag, " ud (R10)"}, 64'(out_ud), 64'(e.ud));
        check(out_wmask == e.mask, {e.tag, " wmask (R6)"}, 64'(out_wmask), 64'(e.mask));
        if (e.mask != 5'd0)
          check(out_flags == e.flags, {e.tag, " flags {OF,SF,ZF,PF,CF}"},
                64'(out_flags), 64'(e.flags));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 16; i++) rf[i] = {16{i[3:0]}};
    rf[0]  = 64'h1234_5678_0000_FF80;
    rf[1]  = 64'hFFFF_FFFF_0000_0000;
    rf[2]  = 64'h8000_0000_0000_0103;
    rf[3]  = 64'h0000_0000_0000_8100;
    rf[4]  = 64'h0000_0000_0000_00F0;
    rf[7]  = 64'h0000_0000_0000_000F;
    rf[12] = 64'hFFFF_0000_8000_0001;
    rf[13] = 64'h8000_0000_8000_0003;

    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset out_valid", 64'(out_valid), 64'd0);
    check(out_wmask == 5'd0, "R6 reset wmask", 64'(out_wmask), 64'd0);
    check(out_ud == 1'b0, "R10 reset ud", 64'(out_ud), 64'd0);
    check(out_flags == 5'd0, "R1 reset flags", 64'(out_flags), 64'd0);
    rst_n = 1'b1;
    idle(2);

    // back-to-back stream
    drive(8'hA8, 8'h00, 0,0,0,0, 0,0, 32'h0000_0080, '0, "R3 acc8 sign");
    drive(8'hA8, 8'h00, 0,0,0,0, 0,0, 32'h0000_0000, '0, "R4 acc8 zero");
    drive(8'hA9, 8'h00, 0,0,0,0, 0,0, 32'hFFFF_FFFF, '0, "R2 acc32");
    drive(8'hA9, 8'h00, 0,0,0,0, 1,0, 32'hFFFF_8000, '0, "R2 acc16 override");
    drive(8'hA9, 8'h00, 1,1,0,0, 1,0, 32'h8000_0000, '0, "R8 acc64 sext, W over override");
    drive(8'h85, 8'hC1, 0,0,0,0, 0,1, 32'h0, '0, "R10 locked 85");
    drive(8'hF7, 8'h05, 1,1,0,0, 0,0, 32'hFFFF_FFFF, 64'h8000_0000_0000_0000, "R7 R8 mem64");
    drive(8'hF6, 8'hD8, 0,0,0,0, 0,0, 32'hFF, '0, "R9 F6 reg=3");
    drive(8'h90, 8'hC0, 0,0,0,0, 0,0, 32'hFF, '0, "R9 other opcode");
    drive(8'h90, 8'hC0, 0,0,0,0, 0,1, 32'hFF, '0, "R9 R10 locked other opcode");
    idle(1);
    drive(8'h84, 8'hE7, 0,0,0,0, 0,0, 32'h0, '0, "R11 high bytes");
    drive(8'h84, 8'hE7, 1,0,0,0, 0,0, 32'h0, '0, "R11 rex low bytes");
    drive(8'h85, 8'hE5, 1,0,1,1, 0,0, 32'h0, '0, "R12 rex extended");
    drive(8'h85, 8'hC2, 0,0,1,1, 0,0, 32'h0, '0, "R12 ext ignored without rex");
    drive(8'hF7, 8'hC1, 0,0,0,0, 0,0, 32'hFFFF_FFFF, '0, "R4 zero at 32 high bits set");
    drive(8'hF7, 8'hC2, 1,1,0,0, 0,0, 32'h0000_0003, '0, "R5 parity at 64");
    drive(8'hF7, 8'hC2, 0,0,0,0, 0,0, 32'h0000_0103, '0, "R5 parity low byte only");
    drive(8'hA8, 8'h00, 0,0,0,0, 1,0, 32'h0000_FF80, '0, "R2 byte ignores override");
    drive(8'h84, 8'h01, 0,0,0,0, 0,0, 32'h0, 64'h0000_0000_0000_0081, "R7 mem8 with reg");
    drive(8'hF7, 8'h00, 0,0,0,0, 0,0, 32'h8000_0000, 64'h8000_0000_8000_0000, "R3 mem32 sign");
    idle(3);
    check(out_valid == 1'b0, "R1 valid drops when idle", 64'(out_valid), 64'd0);
    check(sb.size() == 0, "R1 all results returned", 64'(sb.size()), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule